// File: doc/BRIEF.md
# Reduced-Instruction Boundary-Scan Test Port Controller

This block is the boundary-scan test port of a memory device with separate 18-bit write-data inputs and read-data outputs. A four-wire serial test interface (test clock, mode select, serial in, serial out) steps a sixteen-state controller. The controller moves a 3-bit instruction register or one of three data registers between serial in and serial out. The data registers are a one-bit bypass stage, a 32-bit identification word and a 36-bit boundary ring over the data pins.

The instruction set is deliberately reduced. The ring can only observe the pins. It never drives the pins and never preloads the output buffers. The all-zero code is decoded, but it only observes, like the sampling instructions. One extra instruction samples the pins and also forces the read-data output drivers into high impedance. All unassigned codes fall back to bypass. An active-low asynchronous test reset, or five test-clock rises with mode select held high, returns the controller to its reset state, where the identification instruction is active.

Top module: `bscan_tap_ctrl`

## Requirements
- R1: The state moves on each rising edge of tck according to tms through the sixteen states: Reset, Idle, the Select/Capture/Shift/Exit1/Pause/Exit2/Update states of the data branch, and the same seven states of the instruction branch. From Select-DR, tms high enters Select-IR. From Select-IR, tms high enters Reset. From either Update state, tms high enters Select-DR and tms low enters Idle. trst_n low forces Reset.
- R2: Five consecutive rising edges of tck with tms high reach Reset from any state. In Reset the active instruction becomes 3'b001 (identify).
- R3: The instruction register is 3 bits wide. It loads 3'b001 in Capture-IR, so bit 0 is shifted out first. It shifts from tdi toward bit 0. The shifted value becomes the active instruction only in Update-IR.
- R4: The codes decode as follows. 3'b000 selects the boundary ring and observes only. 3'b001 selects the identification register. 3'b010 selects the boundary ring and floats the outputs. 3'b100 selects the boundary ring and observes only. 3'b111 selects bypass. The reserved codes 3'b011, 3'b101 and 3'b110 select bypass.
- R5: The bypass register is one bit long and captures 0 in Capture-DR.
- R6: The identification register is 32 bits long. It captures parameter ID_VALUE (default 32'h1A2B_C0D5) with bit 0 forced to 1, and shifts bit 0 out first.
- R7: The boundary ring is 36 bits long. In Capture-DR it captures din_pins[i] into bit 2i and dout_pins[i] into bit 2i+1, so bit 0 (din_pins[0]) leaves tdo first.
- R8: dout_hiz is 1 exactly while the active instruction is 3'b010. It changes only at Update-IR or on entry to Reset.
- R9: tdo and tdo_oe change on the falling edge of tck. tdo_oe is 1 only after a falling edge seen in Shift-IR or Shift-DR. While tdo_oe is 0, tdo is 0.
- R10: Pause-DR and the Exit states hold the selected register, so a shift that is interrupted by a pause resumes with the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select, sampled on tck rise |
| tdi | input | 1 | Serial test data in |
| din_pins | input | 18 | Write-data input pins observed by the ring |
| dout_pins | input | 18 | Read-data output pins observed by the ring |
| tdo | output | 1 | Serial test data out, updated on tck fall |
| tdo_oe | output | 1 | Drive enable for tdo |
| dout_hiz | output | 1 | Forces read-data output drivers to high impedance |

## Verification
The bench loads every instruction code and measures the length of the selected path, by shifting eight marker bits past the captured image. A reserved code that selected the wrong register, or a ring of the wrong length, shows up as a shifted marker. The boundary image is compared bit by bit with the pin interleave, which catches a swapped D/Q pair or a reversed ring. A shift interrupted by Pause-DR must resume on the next bit, and a design that shifted while paused drops bits. A long random tms walk, checked against a state model through tdo_oe, catches wrong transition arcs. It is followed by five high tms cycles that must restore the identify instruction and clear the output float from any state reached.

// File: rtl/bscan_tap_pkg.sv
`timescale 1ns/1ps
package bscan_tap_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_RESET    = 4'd0,
        ST_IDLE     = 4'd1,
        ST_DR_SEL   = 4'd2,
        ST_DR_CAP   = 4'd3,
        ST_DR_SHIFT = 4'd4,
        ST_DR_EXIT1 = 4'd5,
        ST_DR_PAUSE = 4'd6,
        ST_DR_EXIT2 = 4'd7,
        ST_DR_UPD   = 4'd8,
        ST_IR_SEL   = 4'd9,
        ST_IR_CAP   = 4'd10,
        ST_IR_SHIFT = 4'd11,
        ST_IR_EXIT1 = 4'd12,
        ST_IR_PAUSE = 4'd13,
        ST_IR_EXIT2 = 4'd14,
        ST_IR_UPD   = 4'd15
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXT_TEST = 3'b000;
    localparam logic [IR_W-1:0] OP_IDENT    = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE_Z = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS   = 3'b111;

    typedef enum logic [1:0] {
        PATH_BYPASS   = 2'd0,
        PATH_IDENT    = 2'd1,
        PATH_BOUNDARY = 2'd2
    } dr_path_e;

    // Reserved codes deliberately fall into the bypass default.
    function automatic dr_path_e decode_path(input logic [IR_W-1:0] op);
        dr_path_e p;
        case (op)
            OP_EXT_TEST: p = PATH_BOUNDARY;
            OP_IDENT:    p = PATH_IDENT;
            OP_SAMPLE_Z: p = PATH_BOUNDARY;
            OP_SAMPLE:   p = PATH_BOUNDARY;
            default:     p = PATH_BYPASS;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
    import bscan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_reset,
    output logic       dr_capture,
    output logic       dr_shift,
    output logic       ir_capture,
    output logic       ir_shift,
    output logic       ir_update
);

    tap_state_e state_nxt;

    // State register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= state_nxt;
    end

    // Transition function
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RESET:    state_nxt = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     state_nxt = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   state_nxt = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   state_nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: state_nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: state_nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: state_nxt = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: state_nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   state_nxt = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   state_nxt = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   state_nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: state_nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: state_nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: state_nxt = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: state_nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   state_nxt = tms ? ST_DR_SEL   : ST_IDLE;
        endcase
    end

    // State-decoded strobes
    always_comb begin
        in_reset   = (state == ST_RESET);
        dr_capture = (state == ST_DR_CAP);
        dr_shift   = (state == ST_DR_SHIFT);
        ir_capture = (state == ST_IR_CAP);
        ir_shift   = (state == ST_IR_SHIFT);
        ir_update  = (state == ST_IR_UPD);
    end

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir #(
    parameter int               W        = 3,
    parameter logic [W-1:0]     RESET_OP = '0
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         tdi,
    input  logic         in_reset,
    input  logic         capture,
    input  logic         shift,
    input  logic         update,
    output logic [W-1:0] op_cur,
    output logic         sr_lsb
);

    localparam logic [W-1:0] CAP_PAT = W'(2'b01);

    logic [W-1:0] sr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr     <= CAP_PAT;
            op_cur <= RESET_OP;
        end else begin
            if (capture)    sr <= CAP_PAT;
            else if (shift) sr <= {tdi, sr[W-1:1]};
            if (in_reset)    op_cur <= RESET_OP;
            else if (update) op_cur <= sr;
        end
    end

    assign sr_lsb = sr[0];

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
    import bscan_tap_pkg::*;
#(
    parameter int              DATA_W   = 18,
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1A2B_C0D5
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  logic              capture,
    input  logic              shift,
    input  dr_path_e          path,
    input  logic [DATA_W-1:0] din_pins,
    input  logic [DATA_W-1:0] dout_pins,
    output logic              dr_lsb
);

    localparam int RING_W = 2 * DATA_W;
    localparam logic [ID_W-1:0] ID_CAP = {ID_VALUE[ID_W-1:1], 1'b1};

    logic [RING_W-1:0] ring_img;
    logic [RING_W-1:0] ring_q;
    logic [ID_W-1:0]   ident_q;
    logic              byp_q;

    // Interleave each input pin with its matching output pin
    for (genvar i = 0; i < DATA_W; i++) begin : g_ring
        assign ring_img[2*i]   = din_pins[i];
        assign ring_img[2*i+1] = dout_pins[i];
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q   <= 1'b0;
            ident_q <= ID_CAP;
            ring_q  <= '0;
        end else begin
            case (path)
                PATH_IDENT: begin
                    if (capture)    ident_q <= ID_CAP;
                    else if (shift) ident_q <= {tdi, ident_q[ID_W-1:1]};
                end
                PATH_BOUNDARY: begin
                    if (capture)    ring_q <= ring_img;
                    else if (shift) ring_q <= {tdi, ring_q[RING_W-1:1]};
                end
                default: begin
                    if (capture)    byp_q <= 1'b0;
                    else if (shift) byp_q <= tdi;
                end
            endcase
        end
    end

    always_comb begin
        case (path)
            PATH_IDENT:    dr_lsb = ident_q[0];
            PATH_BOUNDARY: dr_lsb = ring_q[0];
            default:       dr_lsb = byp_q;
        endcase
    end

endmodule

// File: rtl/bscan_tap_ctrl.sv
`timescale 1ns/1ps
module bscan_tap_ctrl
    import bscan_tap_pkg::*;
#(
    parameter int          DATA_W   = 18,
    parameter logic [31:0] ID_VALUE = 32'h1A2B_C0D5
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    input  logic [DATA_W-1:0] din_pins,
    input  logic [DATA_W-1:0] dout_pins,
    output logic              tdo,
    output logic              tdo_oe,
    output logic              dout_hiz
);

    tap_state_e        state;
    logic              in_reset;
    logic              dr_capture;
    logic              dr_shift;
    logic              ir_capture;
    logic              ir_shift;
    logic              ir_update;
    logic [IR_W-1:0]   ir_cur;
    logic              ir_tdo;
    logic              dr_tdo;
    dr_path_e          path;

    tap_fsm u_fsm (
        .tck        (tck),
        .trst_n     (trst_n),
        .tms        (tms),
        .state      (state),
        .in_reset   (in_reset),
        .dr_capture (dr_capture),
        .dr_shift   (dr_shift),
        .ir_capture (ir_capture),
        .ir_shift   (ir_shift),
        .ir_update  (ir_update)
    );

    tap_ir #(
        .W        (IR_W),
        .RESET_OP (OP_IDENT)
    ) u_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .in_reset (in_reset),
        .capture  (ir_capture),
        .shift    (ir_shift),
        .update   (ir_update),
        .op_cur   (ir_cur),
        .sr_lsb   (ir_tdo)
    );

    assign path = decode_path(ir_cur);

    tap_dr #(
        .DATA_W   (DATA_W),
        .ID_W     (32),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck       (tck),
        .trst_n    (trst_n),
        .tdi       (tdi),
        .capture   (dr_capture),
        .shift     (dr_shift),
        .path      (path),
        .din_pins  (din_pins),
        .dout_pins (dout_pins),
        .dr_lsb    (dr_tdo)
    );

    // Serial output retimed to the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= ir_shift | dr_shift;
            tdo    <= ir_shift ? ir_tdo : (dr_shift ? dr_tdo : 1'b0);
        end
    end

    assign dout_hiz = (ir_cur == OP_SAMPLE_Z);

endmodule

// File: rtl/bscan_tap_ctrl_chk.sv
`timescale 1ns/1ps
module bscan_tap_ctrl_chk
    import bscan_tap_pkg::*;
(
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_cur,
    input logic            ir_tdo,
    input logic            tdo_oe,
    input logic            dout_hiz
);

    logic [2:0] ones_run;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)            ones_run <= 3'd0;
        else if (!tms)          ones_run <= 3'd0;
        else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
    end

    assert_five_ones_reset_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_run == 3'd5) |-> (state == ST_RESET));

    assert_ir_capture_pattern_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_IR_CAP) |=> ir_tdo);

    assert_ir_hold_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_IR_UPD && state != ST_RESET) |=> $stable(ir_cur));

    assert_float_on_update_R8: assert property (@(posedge tck) disable iff (!trst_n)
        $rose(dout_hiz) |-> ($past(state) == ST_IR_UPD));

    assert_tdo_oe_shift_only_R9: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == (state == ST_DR_SHIFT || state == ST_IR_SHIFT));

endmodule

bind bscan_tap_ctrl bscan_tap_ctrl_chk u_chk (
    .tck      (tck),
    .trst_n   (trst_n),
    .tms      (tms),
    .state    (state),
    .ir_cur   (ir_cur),
    .ir_tdo   (ir_tdo),
    .tdo_oe   (tdo_oe),
    .dout_hiz (dout_hiz)
);

// File: tb/bscan_tap_ctrl_test.sv
`timescale 1ns/1ps
module bscan_tap_ctrl_test;

    localparam int CLK_PERIOD = 20;
    localparam logic [31:0] ID_EXP = 32'h1A2B_C0D5;

    // bench-own state numbering for the model
    localparam int M_RST = 0, M_IDLE = 1, M_DSEL = 2, M_DCAP = 3, M_DSH = 4, M_DE1 = 5,
                   M_DPA = 6, M_DE2 = 7, M_DUP = 8, M_ISEL = 9, M_ICAP = 10, M_ISH = 11,
                   M_IE1 = 12, M_IPA = 13, M_IE2 = 14, M_IUP = 15;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic [17:0] din_pins = '0;
    logic [17:0] dout_pins = '0;
    logic        tdo;
    logic        tdo_oe;
    logic        dout_hiz;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    bscan_tap_ctrl uut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .din_pins(din_pins), .dout_pins(dout_pins),
        .tdo(tdo), .tdo_oe(tdo_oe), .dout_hiz(dout_hiz)
    );

    initial forever #(CLK_PERIOD/2) tck = ~tck;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nxt(input int s, input bit m);
        case (s)
            M_RST:  return m ? M_RST  : M_IDLE;
            M_IDLE: return m ? M_DSEL : M_IDLE;
            M_DSEL: return m ? M_ISEL : M_DCAP;
            M_DCAP: return m ? M_DE1  : M_DSH;
            M_DSH:  return m ? M_DE1  : M_DSH;
            M_DE1:  return m ? M_DUP  : M_DPA;
            M_DPA:  return m ? M_DE2  : M_DPA;
            M_DE2:  return m ? M_DUP  : M_DSH;
            M_DUP:  return m ? M_DSEL : M_IDLE;
            M_ISEL: return m ? M_RST  : M_ICAP;
            M_ICAP: return m ? M_IE1  : M_ISH;
            M_ISH:  return m ? M_IE1  : M_ISH;
            M_IE1:  return m ? M_IUP  : M_IPA;
            M_IPA:  return m ? M_IE2  : M_IPA;
            M_IE2:  return m ? M_IUP  : M_ISH;
            default: return m ? M_DSEL : M_IDLE;
        endcase
    endfunction

    function automatic int path_len(input logic [2:0] op);
        case (op)
            3'b001: return 32;
            3'b000, 3'b010, 3'b100: return 36;
            default: return 1;
        endcase
    endfunction

    function automatic logic [63:0] cap_image(input logic [2:0] op, input logic [17:0] d, input logic [17:0] q);
        logic [63:0] v = '0;
        case (op)
            3'b001: v[31:0] = {ID_EXP[31:1], 1'b1};
            3'b000, 3'b010, 3'b100: begin
                for (int i = 0; i < 18; i++) begin
                    v[2*i]   = d[i];
                    v[2*i+1] = q[i];
                end
            end
            default: v = '0;
        endcase
        return v;
    endfunction

    // sample outputs after a falling edge, then drive next tms/tdi
    task automatic step(input bit m, input bit di, output bit o, output bit e);
        @(negedge tck); #1;
        o = tdo; e = tdo_oe;
        tms = m; tdi = di;
    endtask

    task automatic goto_idle();
        bit o, e;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o, e);
        step(1'b0, 1'b0, o, e);
    endtask

    task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
        bit o, e;
        step(1, 0, o, e); step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, op[i], o, e);
            cap[i] = o;
        end
        step(1, 0, o, e); step(0, 0, o, e);
        @(negedge tck); #1;
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        bit o, e;
        dout = '0;
        step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o, e);
            dout[i] = o;
        end
        step(1, 0, o, e); step(0, 0, o, e);
    endtask

    task automatic check_path(input logic [2:0] op, input string req);
        logic [2:0]  cap;
        logic [63:0] din, dout, exp, mask;
        int len;
        din_pins  = 18'($urandom);
        dout_pins = 18'($urandom);
        load_ir(op, cap);
        chk(cap == 3'b001, "R3 capture-IR pattern", 64'(cap), 64'h1);
        chk(dout_hiz == (op == 3'b010), "R8 float follows instruction", 64'(dout_hiz), 64'(op == 3'b010));
        len  = path_len(op);
        din  = {$urandom, $urandom};
        scan_dr(len + 8, din, dout);
        exp  = cap_image(op, din_pins, dout_pins) | ({56'd0, din[7:0]} << len);
        mask = (64'd1 << (len + 8)) - 64'd1;
        chk((dout & mask) == exp, req, dout & mask, exp);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [2:0]  cap;
        logic [63:0] dout, din, exp;
        bit o, e;
        int ms;

        // reset state
        repeat (3) @(negedge tck);
        #1;
        chk(tdo_oe == 1'b0, "R9 tdo_oe low in reset", 64'(tdo_oe), 64'h0);
        chk(tdo == 1'b0, "R9 tdo low in reset", 64'(tdo), 64'h0);
        chk(dout_hiz == 1'b0, "R8 no float in reset", 64'(dout_hiz), 64'h0);
        trst_n = 1'b1;
        goto_idle();

        // identify is active after reset: R2, R6
        din = 64'h00A5;
        scan_dr(40, din, dout);
        exp = {24'd0, 8'hA5, ID_EXP[31:1], 1'b1};
        chk((dout & 64'hFF_FFFF_FFFF) == exp, "R6 ident register after reset (R2)", dout, exp);

        // every code, directed: R4 R5 R6 R7
        for (int c = 0; c < 8; c++) begin
            check_path(3'(c), (path_len(3'(c)) == 1) ? "R4/R5 bypass or reserved path" :
                              (path_len(3'(c)) == 32) ? "R6 ident path" : "R7 boundary ring path");
        end

        // pause in the middle of a boundary shift: R10, R9
        din_pins  = 18'h2D3C1;
        dout_pins = 18'h1B4E7;
        load_ir(3'b100, cap);
        din = {$urandom, $urandom};
        dout = '0;
        step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
        for (int i = 0; i < 10; i++) begin
            step(i == 9, din[i], o, e);
            dout[i] = o;
        end
        step(0, 0, o, e);
        step(0, 0, o, e);
        chk(e == 1'b0, "R9 tdo_oe low in Pause-DR", 64'(e), 64'h0);
        chk(o == 1'b0, "R9 tdo low while disabled", 64'(o), 64'h0);
        step(1, 0, o, e);
        step(0, 0, o, e);
        for (int i = 10; i < 44; i++) begin
            step(i == 43, din[i], o, e);
            dout[i] = o;
        end
        step(1, 0, o, e); step(0, 0, o, e);
        exp = cap_image(3'b100, din_pins, dout_pins) | ({56'd0, din[7:0]} << 36);
        chk((dout & 64'hFFF_FFFF_FFFF) == exp, "R10 pause keeps ring contents (R7)", dout, exp);

        // float then five ones: R8 R2
        load_ir(3'b010, cap);
        chk(dout_hiz == 1'b1, "R8 float active", 64'(dout_hiz), 64'h1);
        for (int i = 0; i < 5; i++) step(1, 0, o, e);
        @(negedge tck); #1;
        chk(dout_hiz == 1'b0, "R2 reset clears float", 64'(dout_hiz), 64'h0);
        step(0, 0, o, e);

        // random tms walk against a state model: R1 R9
        ms = M_IDLE;
        for (int i = 0; i < 400; i++) begin
            bit m;
            m = (($urandom % 8) < 3);
            step(m, 1'($urandom), o, e);
            chk(e == ((ms == M_DSH) || (ms == M_ISH)), "R1 transition model vs tdo_oe (R9)",
                64'(e), 64'((ms == M_DSH) || (ms == M_ISH)));
            ms = nxt(ms, m);
        end

        // five ones from wherever the walk stopped: R2
        for (int i = 0; i < 5; i++) step(1, 0, o, e);
        step(0, 0, o, e);
        din = 64'h3C;
        scan_dr(40, din, dout);
        exp = {24'd0, 8'h3C, ID_EXP[31:1], 1'b1};
        chk((dout & 64'hFF_FFFF_FFFF) == exp, "R2 ident restored after random walk", dout, exp);

        // random instructions and pins: R4 R5 R6 R7 R8
        for (int i = 0; i < 40; i++) begin
            check_path(3'($urandom), "R4 random decode and capture");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule